// File: doc/BRIEF.md
# Memory Refresh Request Generator

This block keeps dynamic or pseudo-static memory alive by asking the bus arbiter for a refresh cycle at a fixed clock interval. A down-counter, reloaded from a programmable interval value, expires once per interval and raises a request. The arbiter answers with a one-cycle acknowledge when it grants the bus. It then runs a dummy memory read, using the address the block presents while its request is high.

The refresh address combines three parts. A running row counter sits just above a zero least-significant bit. Above it is a field of zero bits. A programmable base value fills the top bits, so the refreshed window can be placed on any boundary of that field's size. With the default widths, the row counter drives bits 9..1, bits 12..10 and bit 0 are zero, and bits 19..13 carry the base, which gives an 8 KB placement grid. An enable input gates the whole block.

Top module: `refresh_gen`

## Requirements
- R1: After reset, req_o is 0 and addr_o is 0, and the row counter is 0, so the first refresh address carries row 0.
- R2: After enable_i is sampled high with interval_i = N, req_o rises after max(N,1) rising clock edges. The counter then expires every max(N,1) edges while enable_i stays high.
- R3: req_o stays high until ack_i is sampled high while req_o is high. Several expiries without an acknowledge leave exactly one pending request, which one acknowledge clears.
- R4: The row counter advances by one on each edge where ack_i and req_o are both high, and wraps from its maximum to 0. ack_i while req_o is low has no effect.
- R5: While req_o is high, addr_o bit 0 is 0, bits ROW_W..1 carry the row counter, the next ADDR_W-ROW_W-BASE_W-1 bits are 0, and the top BASE_W bits equal base_i.
- R6: While req_o is low, addr_o is all zeros.
- R7: While enable_i is low, the interval counter holds in reload and any pending request is dropped on the next edge. The row counter is kept, and re-enabling restarts a full interval.
- R8: When an expiry and an acknowledge fall on the same edge, req_o stays high for the new request and the row still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Refresh enable |
| interval_i | input | CNT_W | Clocks between refresh requests |
| base_i | input | BASE_W | Upper address field of the refresh window |
| ack_i | input | 1 | Arbiter grant of the pending refresh |
| req_o | output | 1 | Refresh request to the arbiter |
| addr_o | output | ADDR_W | Refresh address, valid while req_o is high |

## Verification
The bench builds the block with CNT_W=4, ROW_W=3, BASE_W=2 and ADDR_W=8. This lets it sweep all sixteen interval values, including the degenerate 0 and 1 that expire every cycle, and measure the first and the repeated period of each. Because the row counter is only three bits wide, the row wraps several times within the sweep, and all four base values are placed in the address. With a short interval it is easy to line up several expiries before one acknowledge, and to place an acknowledge on an edge that is not an expiry.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  localparam int unsigned DEF_CNT_W  = 9;
  localparam int unsigned DEF_ROW_W  = 9;
  localparam int unsigned DEF_BASE_W = 7;
  localparam int unsigned DEF_ADDR_W = 20;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int unsigned CNT_W = refresh_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // 0 and 1 both mean every clock
  assign expire_o = en_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || expire_o) cnt_q <= interval_i;
    else                        cnt_q <= cnt_q - CNT_W'(1);
  end

  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !expire_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_hold_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !expire_o);
endmodule

// File: rtl/refresh_pending.sv
module refresh_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic expire_i,
  input  logic ack_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       req_q <= 1'b0;
    else if (!en_i)    req_q <= 1'b0;
    else if (expire_i) req_q <= 1'b1;
    else if (ack_i)    req_q <= 1'b0;
  end

  assign req_o = req_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i && en_i) |=> req_q);

  p_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_q);

  p_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && expire_i && ack_i) |=> req_q);
endmodule

// File: rtl/refresh_row.sv
module refresh_row #(
  parameter int unsigned ROW_W = refresh_pkg::DEF_ROW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (step_i) row_q <= row_q + ROW_W'(1);
  end

  assign row_o = row_q;

  p_row_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (row_q == $past(row_q) + ROW_W'(1)));

  p_row_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(row_q));
endmodule

// File: rtl/refresh_addr.sv
module refresh_addr #(
  parameter int unsigned ROW_W  = refresh_pkg::DEF_ROW_W,
  parameter int unsigned BASE_W = refresh_pkg::DEF_BASE_W,
  parameter int unsigned ADDR_W = refresh_pkg::DEF_ADDR_W
) (
  input  logic              valid_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned GAP_W  = ADDR_W - BASE_W - ROW_W - 1;
  localparam int unsigned BASE_LO = ADDR_W - BASE_W;

  logic [ADDR_W-1:0] raw;

  assign raw[0]              = 1'b0;
  assign raw[ROW_W:1]        = row_i;
  assign raw[ADDR_W-1:BASE_LO] = base_i;

  generate
    if (GAP_W > 0) begin : g_gap
      assign raw[BASE_LO-1:ROW_W+1] = '0;
    end
  endgenerate

  assign addr_o = valid_i ? raw : '0;

  initial begin
    a_width_fit_r5: assert (ADDR_W >= BASE_W + ROW_W + 1);
  end
endmodule

// File: rtl/refresh_gen.sv
module refresh_gen #(
  parameter int unsigned CNT_W  = refresh_pkg::DEF_CNT_W,
  parameter int unsigned ROW_W  = refresh_pkg::DEF_ROW_W,
  parameter int unsigned BASE_W = refresh_pkg::DEF_BASE_W,
  parameter int unsigned ADDR_W = refresh_pkg::DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [CNT_W-1:0]  interval_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic             expire;
  logic             req;
  logic [ROW_W-1:0] row;

  refresh_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i),
    .interval_i(interval_i), .expire_o(expire)
  );

  refresh_pending i_pending (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(enable_i),
    .expire_i(expire), .ack_i(ack_i), .req_o(req)
  );

  refresh_row #(.ROW_W(ROW_W)) i_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(req && ack_i), .row_o(row)
  );

  refresh_addr #(.ROW_W(ROW_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) i_addr (
    .valid_i(req), .row_i(row), .base_i(base_i), .addr_o(addr_o)
  );

  assign req_o = req;

  p_addr_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && !expire) |=> (addr_o == '0));
endmodule

// File: tb/test_refresh_gen.sv
module test_refresh_gen;
  localparam int CNT_W = 4, ROW_W = 3, BASE_W = 2, ADDR_W = 8;
  localparam int ROWS = 1 << ROW_W;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ack = 1'b0;
  logic [CNT_W-1:0] interval = '0;
  logic [BASE_W-1:0] base = '0;
  logic req;
  logic [ADDR_W-1:0] addr;

  int tests = 0, fails = 0, exp_row = 0, k;

  always #5 clk = ~clk;

  refresh_gen #(.CNT_W(CNT_W), .ROW_W(ROW_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W))
    i_refresh_gen (.clk_i(clk), .rst_ni(rst_n), .enable_i(en), .interval_i(interval),
                   .base_i(base), .ack_i(ack), .req_o(req), .addr_o(addr));

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
    end
  endtask

  function automatic int exp_addr();
    return (int'(base) << (ADDR_W - BASE_W)) | (exp_row << 1);
  endfunction

  task automatic wait_req(output int n);
    n = 0;
    while (!req && n < 64) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(posedge clk); @(negedge clk);
    ack = 1'b0;
    exp_row = (exp_row + 1) % ROWS;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req == 1'b0, "R1 req after reset", int'(req), 0);
    check(addr == '0, "R1 addr after reset", int'(addr), 0);

    for (int n = 0; n < 16; n++) begin
      en = 1'b0; interval = CNT_W'(n); base = BASE_W'(n % 4);
      @(posedge clk); @(negedge clk);
      check(req == 1'b0, "R7 req dropped while disabled", int'(req), 0);
      check(addr == '0, "R6 addr idle", int'(addr), 0);
      en = 1'b1;
      wait_req(k);
      check(k == ((n < 1) ? 1 : n), "R2 first period", k, (n < 1) ? 1 : n);
      check(int'(addr) == exp_addr(), "R5 addr layout", int'(addr), exp_addr());
      do_ack();
      if (n >= 2) begin
        check(req == 1'b0, "R3 ack clears", int'(req), 0);
        wait_req(k);
        check(k == n - 1, "R2 repeat period", k, n - 1);
        check(int'(addr) == exp_addr(), "R4 row advance", int'(addr), exp_addr());
      end else begin
        check(req == 1'b1, "R8 expire with ack", int'(req), 1);
        check(int'(addr) == exp_addr(), "R8 row advance", int'(addr), exp_addr());
      end
      do_ack();
    end

    // several expiries, one ack
    en = 1'b0; interval = 4'd4; base = 2'd3;
    @(posedge clk); @(negedge clk);
    en = 1'b1;
    repeat (13) @(posedge clk);
    @(negedge clk);
    check(req == 1'b1, "R3 pending held", int'(req), 1);
    do_ack();
    check(req == 1'b0, "R3 single pending", int'(req), 0);
    wait_req(k);
    check(k == 2, "R2 phase kept", k, 2);
    check(int'(addr) == exp_addr(), "R3 one row step", int'(addr), exp_addr());
    do_ack();
    check(req == 1'b0, "R3 ack clears", int'(req), 0);
    ack = 1'b1;
    @(posedge clk); @(negedge clk);
    ack = 1'b0;
    wait_req(k);
    check(k == 2, "R4 idle ack timing", k, 2);
    check(int'(addr) == exp_addr(), "R4 idle ack ignored", int'(addr), exp_addr());

    en = 1'b0;
    @(posedge clk); @(negedge clk);
    check(req == 1'b0, "R7 pending dropped", int'(req), 0);
    check(addr == '0, "R6 addr idle", int'(addr), 0);
    en = 1'b1;
    wait_req(k);
    check(k == 4, "R7 full interval on re-enable", k, 4);
    check(int'(addr) == exp_addr(), "R7 row kept", int'(addr), exp_addr());
    do_ack();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule